// File: doc/BRIEF.md
# Multithreaded warp issue scheduler

This block sits at the front of a multithreaded processing core. It holds a pool of resident warps and issues one instruction per cycle on behalf of one warp. Each warp is a group of 32 threads that execute the same instruction. The scheduler keeps a separate program counter for every warp slot. In each cycle it chooses one warp that is resident and ready, and presents that warp's slot number and program counter together with an issue strobe. Moving from one warp to another costs no cycle, so consecutive issue slots can interleave warps in any order. The instructions of any one warp still issue in program order.

A warp becomes resident when it is launched with a start address. It leaves when its completion is signalled. Outside logic drops a warp's ready flag while that warp waits on a load or a barrier, and the scheduler skips the warp until the flag returns. Selection is round-robin and starts just after the warp that issued last. After an issue, the chosen warp's counter advances by one. If the cycle after the issue brings a branch target, the counter loads that target instead. When the same warp issues again in that cycle, the target is forwarded straight to the output. Fetch, decode, execution and divergence handling sit outside this block.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset no warp is resident and `issue_valid` is low.
- R2: `issue_valid` is high in a cycle exactly when at least one warp is both resident and has its `warp_ready` bit set.
- R3: The warp named on `issue_warp` while `issue_valid` is high is resident and has its ready bit set in that cycle.
- R4: The chosen warp is the first eligible slot when searching upward, with wrap-around, from the slot after the last warp that issued. Before the first issue after reset, the search begins at slot 0.
- R5: The first issue of a launched warp presents its launch address. Each later issue of that warp presents the previous issued address plus one, modulo 2^PC_W, unless a branch target intervenes.
- R6: A `branch_valid` pulse in the cycle after a warp issued replaces that warp's next address with `branch_pc`. If that warp issues again in that same cycle, `issue_pc` already shows `branch_pc`.
- R7: A resident warp whose ready bit is low is skipped, and its program counter holds. When the bit returns, the warp resumes at the address it would have issued next.
- R8: After a completion pulse on `done_valid`/`done_id`, that warp does not issue until it is launched again.
- R9: Whenever an eligible warp exists, one issue happens in that cycle, so a change of warp between cycles leaves no idle slot.
- R10: `branch_valid` has no effect in a cycle that follows a cycle without an issue.
- R11: A launch of a slot overrides, for that slot's address and residency, any issue advance, branch target or completion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per-slot ready flag; low while a warp waits on a load or barrier |
| launch_valid | input | 1 | Launch a warp into slot `launch_id` |
| launch_id | input | WID_W | Slot being launched |
| launch_pc | input | PC_W | Start address of the launched warp |
| done_valid | input | 1 | Completion pulse for slot `done_id` |
| done_id | input | WID_W | Slot that completes |
| branch_valid | input | 1 | Branch target for the warp that issued in the previous cycle |
| branch_pc | input | PC_W | Branch target address |
| issue_valid | output | 1 | Issue strobe |
| issue_warp | output | WID_W | Slot of the issuing warp |
| issue_pc | output | PC_W | Address issued for that warp |

## Verification
Some properties are checked by assertions on every cycle. These are: the issued warp is eligible; the strobe is high exactly when some eligible warp exists; back-to-back issues of one warp step the address by one; a forwarded branch target appears on the same cycle; and a completed warp does not issue in the next cycle. The round-robin order needs the bench's cycle-level model. So do the hold-and-resume of stalled warps, the address wrap at the top of the counter, the branch pulse that is ignored after an idle cycle, and the precedence of a launch over a concurrent advance, branch or completion. The bench runs these over sweeps of every ready mask on a four-slot configuration.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Per-slot program counter update chosen in a cycle
  typedef enum logic [1:0] {
    PC_HOLD = 2'd0,
    PC_STEP = 2'd1,
    PC_JUMP = 2'd2,
    PC_LOAD = 2'd3
  } pc_op_e;

  // Circular successor of a slot index in a pool of n slots
  function automatic int unsigned slot_after(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int NUM_WARPS = 32,
  parameter int WID_W     = 5
) (
  input  logic [NUM_WARPS-1:0] eligible,
  input  logic [WID_W-1:0]     last_slot,
  output logic                 found,
  output logic [WID_W-1:0]     pick
);
  import warp_sched_pkg::*;

  // Scan starting just past the last issuer, wrapping once around the pool
  always_comb begin
    int unsigned idx;
    found = 1'b0;
    pick  = '0;
    idx   = slot_after(int'(last_slot), NUM_WARPS);
    for (int k = 0; k < NUM_WARPS; k++) begin
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = WID_W'(idx);
      end
      idx = slot_after(idx, NUM_WARPS);
    end
  end

endmodule

// File: rtl/warp_pc_table.sv
module warp_pc_table #(
  parameter int NUM_WARPS = 32,
  parameter int WID_W     = 5,
  parameter int PC_W      = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           step_en,
  input  logic [WID_W-1:0]               step_id,
  input  logic [PC_W-1:0]                step_pc,
  input  logic                           jump_en,
  input  logic [WID_W-1:0]               jump_id,
  input  logic [PC_W-1:0]                jump_pc,
  input  logic                           load_en,
  input  logic [WID_W-1:0]               load_id,
  input  logic [PC_W-1:0]                load_pc,
  input  logic                           drop_en,
  input  logic [WID_W-1:0]               drop_id,
  output logic [NUM_WARPS-1:0]           resident,
  output logic [NUM_WARPS-1:0][PC_W-1:0] pc_q
);
  import warp_sched_pkg::*;

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
    logic            res_r;
    logic [PC_W-1:0] pc_r;
    logic            hit_ld, hit_st, hit_jp, hit_dr;
    pc_op_e          op;

    assign hit_ld = load_en && (load_id == WID_W'(w));
    assign hit_st = step_en && (step_id == WID_W'(w));
    assign hit_jp = jump_en && (jump_id == WID_W'(w));
    assign hit_dr = drop_en && (drop_id == WID_W'(w));

    // Launch outranks the issue advance, which outranks a late branch
    always_comb begin
      if (hit_ld)      op = PC_LOAD;
      else if (hit_st) op = PC_STEP;
      else if (hit_jp) op = PC_JUMP;
      else             op = PC_HOLD;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_r <= 1'b0;
        pc_r  <= '0;
      end else begin
        if (hit_ld)      res_r <= 1'b1;
        else if (hit_dr) res_r <= 1'b0;
        case (op)
          PC_LOAD: pc_r <= load_pc;
          PC_STEP: pc_r <= step_pc;
          PC_JUMP: pc_r <= jump_pc;
          default: pc_r <= pc_r;
        endcase
      end
    end

    assign resident[w] = res_r;
    assign pc_q[w]     = pc_r;
  end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 32,
  parameter int PC_W      = 16,
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_ready,
  input  logic                 launch_valid,
  input  logic [WID_W-1:0]     launch_id,
  input  logic [PC_W-1:0]      launch_pc,
  input  logic                 done_valid,
  input  logic [WID_W-1:0]     done_id,
  input  logic                 branch_valid,
  input  logic [PC_W-1:0]      branch_pc,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_warp,
  output logic [PC_W-1:0]      issue_pc
);

  function automatic logic [PC_W-1:0] pc_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(1);
  endfunction

  // Named internal events
  logic [NUM_WARPS-1:0]           resident;
  logic [NUM_WARPS-1:0][PC_W-1:0] pc_q;
  logic [NUM_WARPS-1:0]           eligible;
  logic                           found;
  logic [WID_W-1:0]               pick;
  logic [WID_W-1:0]               last_slot;
  logic                           issued_prev;
  logic                           branch_hit;
  logic                           branch_fwd;
  logic                           branch_late;
  logic [PC_W-1:0]                sel_pc;

  assign eligible    = resident & warp_ready;
  assign branch_hit  = branch_valid && issued_prev;
  assign branch_fwd  = branch_hit && found && (pick == last_slot);
  assign branch_late = branch_hit && !branch_fwd;
  assign sel_pc      = branch_fwd ? branch_pc : pc_q[pick];

  warp_rr_pick #(
    .NUM_WARPS (NUM_WARPS),
    .WID_W     (WID_W)
  ) u_pick (
    .eligible  (eligible),
    .last_slot (last_slot),
    .found     (found),
    .pick      (pick)
  );

  warp_pc_table #(
    .NUM_WARPS (NUM_WARPS),
    .WID_W     (WID_W),
    .PC_W      (PC_W)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (found),
    .step_id  (pick),
    .step_pc  (pc_next(sel_pc)),
    .jump_en  (branch_late),
    .jump_id  (last_slot),
    .jump_pc  (branch_pc),
    .load_en  (launch_valid),
    .load_id  (launch_id),
    .load_pc  (launch_pc),
    .drop_en  (done_valid),
    .drop_id  (done_id),
    .resident (resident),
    .pc_q     (pc_q)
  );

  // Last issuer: round-robin origin and owner of a late branch target
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_slot   <= WID_W'(NUM_WARPS - 1);
      issued_prev <= 1'b0;
    end else begin
      issued_prev <= found;
      if (found) last_slot <= pick;
    end
  end

  assign issue_valid = found;
  assign issue_warp  = pick;
  assign issue_pc    = sel_pc;

  // R3: the issuing slot is resident and ready
  p_sel_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (resident[issue_warp] && warp_ready[issue_warp]));

  // R2 / R9: a slot is lost only when nothing is eligible
  p_work_conserving_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(resident & warp_ready)) == issue_valid);

  // R5: back-to-back issues of one warp step the address by one
  p_pc_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_valid) && issue_valid && issue_warp == $past(issue_warp) &&
     !branch_valid && !($past(launch_valid) && $past(launch_id) == issue_warp))
    |-> issue_pc == PC_W'($past(issue_pc) + PC_W'(1)));

  // R6: a branch target is forwarded when its warp issues again at once
  p_branch_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(issue_valid) && branch_valid && issue_valid &&
     issue_warp == $past(issue_warp) &&
     !($past(launch_valid) && $past(launch_id) == issue_warp))
    |-> issue_pc == branch_pc);

  // R8: a completed warp does not issue in the following cycle
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !(launch_valid && launch_id == done_id))
    |=> !(issue_valid && issue_warp == $past(done_id)));

endmodule

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int N  = 4;
  localparam int PW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  warp_ready = '0;
  logic          launch_valid = 1'b0;
  logic [IW-1:0] launch_id = '0;
  logic [PW-1:0] launch_pc = '0;
  logic          done_valid = 1'b0;
  logic [IW-1:0] done_id = '0;
  logic          branch_valid = 1'b0;
  logic [PW-1:0] branch_pc = '0;
  logic          issue_valid;
  logic [IW-1:0] issue_warp;
  logic [PW-1:0] issue_pc;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state derived from the requirements
  int m_res [N];
  int m_pc  [N];
  int m_last;
  int m_prev;

  always #2 clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(N), .PC_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .warp_ready(warp_ready),
    .launch_valid(launch_valid), .launch_id(launch_id), .launch_pc(launch_pc),
    .done_valid(done_valid), .done_id(done_id),
    .branch_valid(branch_valid), .branch_pc(branch_pc),
    .issue_valid(issue_valid), .issue_warp(issue_warp), .issue_pc(issue_pc)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs set; checks, clocks, updates the model
  task automatic step(input string tag);
    int e_any, e_w, e_pc, idx, fwd;
    #1;
    e_any = 0; e_w = 0;
    idx = m_last;
    for (int k = 0; k < N; k++) begin
      idx = (idx + 1) % N;
      if (!e_any && m_res[idx] != 0 && warp_ready[idx]) begin
        e_any = 1; e_w = idx;
      end
    end
    fwd  = (branch_valid && m_prev != 0 && e_any != 0 && e_w == m_last) ? 1 : 0;
    e_pc = fwd ? int'(branch_pc) : m_pc[e_w];
    chk(issue_valid == e_any, tag, "R2 issue_valid", int'(issue_valid), e_any);
    if (e_any != 0 && issue_valid) begin
      chk(int'(issue_warp) == e_w, tag, "R4 issue_warp", int'(issue_warp), e_w);
      chk(int'(issue_pc) == e_pc, tag, fwd ? "R6 issue_pc" : "R5 issue_pc", int'(issue_pc), e_pc);
    end
    @(posedge clk);
    if (branch_valid && m_prev != 0 && fwd == 0) m_pc[m_last] = int'(branch_pc);
    if (e_any != 0) m_pc[e_w] = (e_pc + 1) % (1 << PW);
    if (done_valid) m_res[done_id] = 0;
    if (launch_valid) begin
      m_res[launch_id] = 1;
      m_pc[launch_id]  = int'(launch_pc);
    end
    m_prev = e_any;
    if (e_any != 0) m_last = e_w;
    @(negedge clk);
    launch_valid = 1'b0;
    done_valid   = 1'b0;
    branch_valid = 1'b0;
  endtask

  task automatic launch(input int id, input int pc);
    launch_valid = 1'b1;
    launch_id    = IW'(id);
    launch_pc    = PW'(pc);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < N; w++) begin m_res[w] = 0; m_pc[w] = 0; end
    m_last = N - 1;
    m_prev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: nothing resident out of reset, even with every ready bit set
    warp_ready = '1;
    #1;
    chk(issue_valid == 1'b0, "R1", "issue_valid after reset", int'(issue_valid), 0);
    step("R1");

    // R5: launch all slots; issue starts on the next cycle at the launch address
    for (int w = 0; w < N; w++) begin
      launch(w, 16 * w + 3);
      step("R5");
    end
    repeat (6) step("R9");

    // R3, R4, R7: every ready mask held for three cycles
    for (int m = 0; m < (1 << N); m++) begin
      warp_ready = N'(m);
      repeat (3) step("R7");
    end

    // R6, R10: branch pulses mixed with changing masks, including after idle cycles
    for (int i = 0; i < 48; i++) begin
      warp_ready   = N'((i * 5 + 3) % 16);
      branch_valid = (i % 3 == 1);
      branch_pc    = PW'((i * 37) & 255);
      step((i == 10) ? "R10" : "R6");
    end

    // R6: one ready warp, back-to-back issue with forwarded targets
    warp_ready = 4'b0100;
    for (int i = 0; i < 8; i++) begin
      branch_valid = (i % 2 == 1);
      branch_pc    = PW'(200 + i);
      step("R6");
    end

    // R8: complete slot 1, then confirm it never issues
    warp_ready = '1;
    done_valid = 1'b1;
    done_id    = 2'd1;
    step("R8");
    repeat (8) step("R8");

    // R5: relaunch slot 1 at the top address so it wraps to zero
    warp_ready = 4'b0010;
    launch(1, 255);
    step("R5");
    repeat (3) step("R5");

    // R11: launch collides with issue, branch and completion of slot 2
    warp_ready = 4'b0100;
    step("R11");
    launch(2, 100);
    branch_valid = 1'b1;
    branch_pc    = 8'd7;
    done_valid   = 1'b1;
    done_id      = 2'd2;
    step("R11");
    repeat (3) step("R11");

    // R9: all ready again, rotation with no idle slot
    warp_ready = '1;
    repeat (8) step("R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule